// File: doc/BRIEF.md
# Quadrature Phase-Counting Timer Channel

A timer channel with a `CNT_W`-bit counter, one compare/capture register and two sticky status flags. In its normal mode the counter advances on a chosen clock source. That source is the system clock, a prescaled tick, or edges of an external clock pin.

Setting the phase-mode bit turns the counter into a 4x quadrature up/down counter. In that mode the counter is driven only by two phase pins, A and B. Every edge of either pin moves the count by one. The direction depends on which pin moved and on the level of the other pin. The source and edge selections are ignored while phase mode is on. Counter clearing, compare match, input capture, the flags and the interrupt keep working as in normal mode.

All four pins are asynchronous. Each passes through a two-flop synchronizer and one more flop for edge detection, so a pin change reaches the counter three clocks after it arrives. Software writes registers through a single write port. Software also pulses `stat_rd` when it reads the status, which arms the clearing of a set flag.

Top module: `qtimer_channel`

## Requirements
- R1: After reset the counter, the compare/capture register, both flags and `irq` are 0. The control word is all zero, which stops the counter.
- R2: With control bit 0 set (phase mode), the count rises by one in each of these cases: A rises while B is low, B rises while A is high, A falls while B is high, or B falls while A is low.
- R3: In phase mode the mirror transitions lower the count by one. These are A rising with B high, B rising with A low, A falling with B low, and B falling with A high.
- R4: In phase mode, a synchronized sample in which A and B both changed leaves the count unchanged.
- R5: In phase mode the source field (control bits 2:1) and the edge field (control bits 4:3) have no effect, and neither does the external clock pin.
- R6: In normal mode the source field selects how the counter steps up. Code 0 stops it. Code 1 steps it every clock. Code 2 steps it once every `PRESC_DIV` clocks.
- R7: With source code 3, the counter steps on synchronized edges of `ext_clk`. Edge code 0 counts rising edges, code 1 counts falling edges, and codes 2 and 3 count both.
- R8: Counting up from all ones wraps the counter to 0 and sets `ovf_flag`.
- R9: Counting down from 0 wraps the counter to all ones. It sets `ovf_flag` only while control bit 7 is 0. This holds in every mode.
- R10: A set flag clears only after a write of 0 to its status bit (address 2: bit 0 is the overflow flag, bit 1 is the match flag), and only if `stat_rd` was pulsed while the flag was set. A write of 0 without that prior read leaves the flag set.
- R11: With control bit 8 at 0, a count step that lands on the register value (address 1) sets `match_flag`. When the clear field (control bits 6:5) is 1, the counter reads 0 one clock after that match.
- R12: With control bit 8 at 1, a synchronized rising edge of `cap_pin` copies the counter into the register and sets `match_flag`. When the clear field is 2, the same edge also clears the counter.
- R13: `irq` is high while `ovf_flag` is set with control bit 9 at 1, or while `match_flag` is set with control bit 10 at 1. Address 3 writes the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase_a | input | 1 | Phase input A, asynchronous |
| phase_b | input | 1 | Phase input B, asynchronous |
| ext_clk | input | 1 | External count clock pin, asynchronous |
| cap_pin | input | 1 | Input-capture trigger pin, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 compare/capture, 2 status, 3 counter |
| wr_data | input | CNT_W | Write data (CNT_W must be at least 11) |
| stat_rd | input | 1 | Status read strobe, arms flag clearing |
| count | output | CNT_W | Counter value |
| gr_val | output | CNT_W | Compare/capture register |
| ovf_flag | output | 1 | Overflow/underflow flag |
| match_flag | output | 1 | Compare-match or capture flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the channel with the default 16-bit counter and `PRESC_DIV` of 4. This makes the prescaled source measurable as exactly five steps in a 20-clock window. Both wrap points are reached by loading the counter through address 3 rather than by counting there. A table walks the phase pins through all eight single-pin transitions and two simultaneous changes. Directed tests then cover the mode override, the edge choices, the flag handshake, match clearing and capture.

// File: rtl/qtimer_channel.sv
module qtimer_channel #(
  parameter int CNT_W     = 16,
  parameter int PRESC_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic             ext_clk,
  input  logic             cap_pin,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             stat_rd,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] gr_val,
  output logic             ovf_flag,
  output logic             match_flag,
  output logic             irq
);
  localparam int CTRL_W = 11;
  localparam int PW     = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;

  logic [3:0] sy1, sy2, sy3;
  logic [CTRL_W-1:0] ctrl_q;
  logic [PW-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q, gr_q, cnt_nxt;
  logic ovf_q, mf_q, ovf_arm, mf_arm, match_d;
  logic unused_bits;

  assign unused_bits = ^wr_data[CNT_W-1:CTRL_W];

  // pins: 0=A 1=B 2=ext clock 3=capture
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '0; sy2 <= '0; sy3 <= '0;
    end else begin
      sy1 <= {cap_pin, ext_clk, phase_b, phase_a};
      sy2 <= sy1;
      sy3 <= sy2;
    end

  wire       phase_en = ctrl_q[0];
  wire [1:0] src_sel  = ctrl_q[2:1];
  wire [1:0] edge_sel = ctrl_q[4:3];
  wire [1:0] clr_sel  = ctrl_q[6:5];
  wire       ovf_only = ctrl_q[7];
  wire       cap_mode = ctrl_q[8];
  wire       ovf_ie   = ctrl_q[9];
  wire       mf_ie    = ctrl_q[10];

  wire wr_ctrl = wr_en && wr_addr == 2'd0;
  wire wr_gr   = wr_en && wr_addr == 2'd1;
  wire wr_stat = wr_en && wr_addr == 2'd2;
  wire wr_cnt  = wr_en && wr_addr == 2'd3;

  wire qa_chg = sy2[0] ^ sy3[0];
  wire qb_chg = sy2[1] ^ sy3[1];
  wire q_step = phase_en && (qa_chg ^ qb_chg);
  wire q_up   = qa_chg ? (sy2[0] ^ sy2[1]) : ~(sy2[0] ^ sy2[1]);

  wire ext_rise = sy2[2] & ~sy3[2];
  wire ext_fall = ~sy2[2] & sy3[2];
  wire tick     = (pre_q == PW'(PRESC_DIV - 1));
  wire cap_evt  = cap_mode && sy2[3] && !sy3[3];

  logic n_step;
  always_comb begin
    unique case (src_sel)
      2'd0: n_step = 1'b0;
      2'd1: n_step = 1'b1;
      2'd2: n_step = tick;
      default:
        unique case (edge_sel)
          2'd0:    n_step = ext_rise;
          2'd1:    n_step = ext_fall;
          default: n_step = ext_rise | ext_fall;
        endcase
    endcase
  end

  wire step = phase_en ? q_step : n_step;
  wire up   = phase_en ? q_up : 1'b1;
  assign cnt_nxt = up ? cnt_q + 1'b1 : cnt_q - 1'b1;

  wire ovf_evt   = step && up && (cnt_q == '1);
  wire unf_evt   = step && !up && (cnt_q == '0);
  wire match_evt = step && !cap_mode && (cnt_nxt == gr_q);
  wire clr_now   = (clr_sel == 2'd1 && match_d) || (clr_sel == 2'd2 && cap_evt);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre_q <= '0;
    else        pre_q <= tick ? '0 : pre_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= wr_data[CTRL_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q   <= '0;
      match_d <= 1'b0;
    end else begin
      match_d <= match_evt;
      if (wr_cnt)       cnt_q <= wr_data;
      else if (clr_now) cnt_q <= '0;
      else if (step)    cnt_q <= cnt_nxt;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       gr_q <= '0;
    else if (wr_gr)   gr_q <= wr_data;
    else if (cap_evt) gr_q <= cnt_q;

  wire ovf_set = ovf_evt || (unf_evt && !ovf_only);
  wire mf_set  = match_evt || cap_evt;
  wire ovf_clr = wr_stat && !wr_data[0] && ovf_arm;
  wire mf_clr  = wr_stat && !wr_data[1] && mf_arm;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ovf_q <= 1'b0; mf_q <= 1'b0; ovf_arm <= 1'b0; mf_arm <= 1'b0;
    end else begin
      if (ovf_set)      ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
      if (mf_set)       mf_q <= 1'b1;
      else if (mf_clr)  mf_q <= 1'b0;
      if (ovf_clr && !ovf_set)    ovf_arm <= 1'b0;
      else if (stat_rd && ovf_q)  ovf_arm <= 1'b1;
      if (mf_clr && !mf_set)      mf_arm <= 1'b0;
      else if (stat_rd && mf_q)   mf_arm <= 1'b1;
    end

  assign count      = cnt_q;
  assign gr_val     = gr_q;
  assign ovf_flag   = ovf_q;
  assign match_flag = mf_q;
  assign irq        = (ovf_q && ovf_ie) || (mf_q && mf_ie);

  assert_quad_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (q_step && q_up && !wr_cnt && !clr_now) |=> cnt_q == $past(cnt_q) + 1'b1);

  assert_quad_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (q_step && !q_up && !wr_cnt && !clr_now) |=> cnt_q == $past(cnt_q) - 1'b1);

  assert_dual_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_en && qa_chg && qb_chg && !wr_cnt && !clr_now) |=> $stable(cnt_q));

  assert_unf_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_evt && ovf_only && !ovf_q) |=> !ovf_q);

  assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_arm) |=> ovf_q);

  assert_match_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !wr_cnt && !clr_now) |=> (cnt_q == gr_q) && mf_q);

  assert_capture_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && !wr_gr) |=> gr_q == $past(cnt_q));
endmodule

// File: tb/qtimer_channel_test.sv
module qtimer_channel_test;
  localparam int W = 16;
  logic clk = 0, rst_n = 0;
  logic pa = 0, pb = 0, ek = 0, cp = 0;
  logic wr_en = 0, stat_rd = 0;
  logic [1:0] wr_addr = 0;
  logic [W-1:0] wr_data = 0;
  logic [W-1:0] count, gr_val;
  logic ovf_flag, match_flag, irq;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  qtimer_channel #(.CNT_W(W), .PRESC_DIV(4)) uut (
    .clk(clk), .rst_n(rst_n), .phase_a(pa), .phase_b(pb), .ext_clk(ek),
    .cap_pin(cp), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .stat_rd(stat_rd), .count(count), .gr_val(gr_val), .ovf_flag(ovf_flag),
    .match_flag(match_flag), .irq(irq));

  // {A, B, expected count}; count preloaded to 100 with A=B=0
  localparam logic [17:0] QV [10] = '{
    {2'b10, 16'd101},  // R2 A rise, B low
    {2'b11, 16'd102},  // R2 B rise, A high
    {2'b01, 16'd103},  // R2 A fall, B high
    {2'b00, 16'd104},  // R2 B fall, A low
    {2'b01, 16'd103},  // R3 B rise, A low
    {2'b11, 16'd102},  // R3 A rise, B high
    {2'b10, 16'd101},  // R3 B fall, A high
    {2'b00, 16'd100},  // R3 A fall, B low
    {2'b11, 16'd100},  // R4 both change
    {2'b00, 16'd100}   // R4 both change
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic waitc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pins(logic a, logic b);
    @(negedge clk); pa = a; pb = b;
    waitc(5);
  endtask

  task automatic clr_flags();
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
    wr(2, 0);
    waitc(1);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] c0;
    waitc(3);
    rst_n = 1;
    waitc(4);
    // R1 reset state, counter stopped
    check("R1 count", count, 0);
    check("R1 gr", gr_val, 0);
    check("R1 flags/irq", {ovf_flag, match_flag, irq}, 0);

    // R2 R3 R4 table
    wr(0, 16'h0001);
    wr(3, 16'd100);
    for (int i = 0; i < 10; i++) begin
      pins(QV[i][17], QV[i][16]);
      check($sformatf("R%0d vector %0d", (i < 4) ? 2 : (i < 8) ? 3 : 4, i), count, QV[i][15:0]);
    end

    // R5 phase mode ignores sysclk source and ext clock edges
    wr(0, 16'h0003);
    c0 = count;
    waitc(3); ek = 1; waitc(3); ek = 0; waitc(6);
    check("R5 sysclk ignored", count, c0);
    wr(0, 16'h0007);
    ek = 1; waitc(4); ek = 0; waitc(4);
    check("R5 ext pin ignored", count, c0);

    // R6 normal sources
    wr(0, 16'h0000); wr(3, 0);
    wr(0, 16'h0002);
    c0 = count; waitc(10);
    check("R6 every clock", count, c0 + 10);
    wr(0, 16'h0000);
    c0 = count; waitc(8);
    check("R6 stopped", count, c0);
    wr(0, 16'h0004);
    c0 = count; waitc(20);
    check("R6 prescaled", count, c0 + 5);

    // R7 external edge selection
    wr(0, 16'h0000); wr(3, 0);
    wr(0, 16'h0006);
    ek = 1; waitc(5); ek = 0; waitc(5);
    check("R7 rising", count, 1);
    wr(0, 16'h000E);
    ek = 1; waitc(5); ek = 0; waitc(5);
    check("R7 falling", count, 2);
    wr(0, 16'h0016);
    ek = 1; waitc(5); ek = 0; waitc(5);
    check("R7 both", count, 4);

    // R8 overflow, R10 handshake, R13 irq masked
    wr(0, 16'h0001); wr(3, 16'hFFFF);
    pins(1, 0);
    check("R8 wrap", count, 0);
    check("R8 flag", ovf_flag, 1);
    check("R13 masked", irq, 0);
    wr(0, 16'h0201); waitc(1);
    check("R13 ovf irq", irq, 1);
    wr(2, 0); waitc(1);
    check("R10 no read, stays", ovf_flag, 1);
    clr_flags();
    check("R10 read then clear", ovf_flag, 0);
    check("R13 irq drops", irq, 0);

    // R9 underflow
    wr(3, 0);
    pins(0, 0);
    check("R9 wrap", count, 16'hFFFF);
    check("R9 flag bit7=0", ovf_flag, 1);
    clr_flags();
    wr(0, 16'h0081); wr(3, 0);
    pins(0, 1);
    check("R9 wrap masked", count, 16'hFFFF);
    check("R9 flag bit7=1", ovf_flag, 0);
    wr(3, 16'hFFFF);
    pins(0, 0);
    check("R9 overflow still flags", ovf_flag, 1);
    clr_flags();

    // R11 compare match with clear, phase mode
    wr(0, 16'h0421); wr(1, 3); wr(3, 1);
    pins(1, 0);
    check("R11 before match", {match_flag, count}, {1'b0, 16'd2});
    pins(1, 1);
    check("R11 clear on match", count, 0);
    check("R11 flag", match_flag, 1);
    check("R13 match irq", irq, 1);
    clr_flags();
    check("R10 match flag clear", match_flag, 0);

    // R12 capture with clear
    wr(0, 16'h0140); wr(3, 16'h1234);
    cp = 1; waitc(5); cp = 0; waitc(2);
    check("R12 captured", gr_val, 16'h1234);
    check("R12 cleared", count, 0);
    check("R12 flag", match_flag, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule